// File: doc/BRIEF.md
# Private Interrupt Pending Tracker with Software Interrupt Acceptance

This block keeps the pending state of the 32 interrupts private to one processor. IDs 16 to 31 are peripheral lines driven by wire levels. IDs 0 to 15 are software-generated and arrive as requests. A request carries its ID, a requested group and a non-secure flag. The block stores each peripheral line level. For lines configured as edge-triggered it latches a pending bit on a rising change. For lines configured as level-triggered it reports the stored level directly. The effective pending vector is the latch merged with those live levels.

Each software request passes an acceptance gate before it may set pending. The gate first derives the interrupt's configured group from a group bit and a modifier bit. It then coerces the requested group where the rules allow, drops the request if the groups differ, and finally applies a graded permission check for non-secure requests. That check reads a 2-bit access field held for each interrupt.

A register interface can set and clear pending bits with single-cycle pulses. A second output gives the interrupts that are ready to deliver, which are those pending, enabled and not active. Choosing among them by priority is left to the logic downstream.

Top module: `priv_pend_ctrl`

## Requirements
- R1: While rst_ni is low, pend_o and deliv_o are all zero, even when set_pend_i is asserted.
- R2: Line k of line_i maps to ID 16+k. On an ID with edge_cfg_i set to 1, a 0-to-1 change of the stored level sets the pending latch, and pend_o shows it one cycle after the clock edge that samples the new level. The latch stays set after the line falls. A line held high with no change never sets the latch again.
- R3: On an ID with edge_cfg_i set to 0, pend_o follows the stored line level with one cycle of latency, both when the line rises and when it falls.
- R4: pend_o is the pending latch OR (stored level AND NOT edge_cfg_i). A level-triggered ID whose latch is set stays pending after its line falls. A level-triggered ID whose line is high stays pending after a clear pulse.
- R5: A set_pend_i bit sets the latch and a clr_pend_i bit clears it, both at the next edge. When both pulses hit the same bit in the same cycle, the set wins.
- R6: The requested group is encoded 0 for group 0, 1 for secure group 1, 2 for non-secure group 1, and 3 is invalid. The configured group is non-secure group 1 when grp_cfg_i is 1. When grp_cfg_i is 0, it is secure group 1 if grp_mod_i is 1 and group 0 if grp_mod_i is 0. A request for secure group 1 aimed at a group-0 interrupt is treated as group 0.
- R7: After that coercion, a request whose group differs from the configured group is dropped. A request with encoding 3 is always dropped.
- R8: With security enabled (sec_off_i=0), a non-secure request for ID n reads ns_acc_i[2n+1:2n]. The request is dropped if that field is below 1 for a group-0 interrupt, or below 2 for a secure group-1 interrupt. Non-secure group-1 interrupts are not restricted by the field.
- R9: When sec_off_i=1, non-secure requests skip the access-field check.
- R10: An accepted request sets the pending latch bit of its ID at the next edge. It sets no other bit.
- R11: deliv_o equals pend_o AND en_i AND NOT act_i.
- R12: A set from a rising edge-triggered line, or from an accepted request, takes priority over a clr_pend_i pulse to the same bit in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 16 | Peripheral interrupt line levels; bit k is ID 16+k |
| sgi_req_i | input | 1 | Software interrupt request valid (single cycle) |
| sgi_id_i | input | 4 | Requested interrupt ID, 0 to 15 |
| sgi_grp_i | input | 2 | Requested group (0 G0, 1 secure G1, 2 non-secure G1, 3 invalid) |
| sgi_ns_i | input | 1 | Request comes from the non-secure side |
| sec_off_i | input | 1 | Security disabled |
| grp_cfg_i | input | 32 | Group bit per interrupt |
| grp_mod_i | input | 32 | Group modifier bit per interrupt |
| ns_acc_i | input | 32 | Non-secure access field, 2 bits per software ID |
| edge_cfg_i | input | 32 | 1 = edge-triggered, 0 = level-triggered |
| en_i | input | 32 | Interrupt enable per ID |
| act_i | input | 32 | Interrupt active per ID |
| set_pend_i | input | 32 | Set-pending pulses |
| clr_pend_i | input | 32 | Clear-pending pulses |
| pend_o | output | 32 | Effective pending vector |
| deliv_o | output | 32 | Pending, enabled and not active |

## Verification
A wrong stored level or pending latch shows on pend_o one cycle after the edge that would have changed it. The same fault reaches deliv_o in the same cycle for any enabled, inactive ID. A flaw in the acceptance gate shows one cycle after the request, as a missing bit, a stray bit, or a bit at the wrong ID. To expose such flaws, the request vectors fill every access field except the target with the opposite value and set every group bit except the target to the opposite value. A gate that reads the wrong position, coerces in the wrong direction or grades the permission wrongly therefore flips the expected bit. Latch priority faults show when edge rises, set pulses and clear pulses collide on one bit in one cycle.

// File: rtl/priv_pend_pkg.sv
package priv_pend_pkg;

  typedef enum logic [1:0] {
    GRP_0   = 2'd0,
    GRP_1S  = 2'd1,
    GRP_1NS = 2'd2,
    GRP_BAD = 2'd3
  } grp_e;

  function automatic grp_e cfg_grp(input logic grp_bit, input logic mod_bit);
    if (grp_bit) return GRP_1NS;
    return mod_bit ? GRP_1S : GRP_0;
  endfunction

  // minimum access field a non-secure request needs per configured group
  function automatic logic [1:0] ns_min_field(input grp_e cfg);
    case (cfg)
      GRP_0:   return 2'd1;
      GRP_1S:  return 2'd2;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/ppg_line_sampler.sv
module ppg_line_sampler #(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  localparam int NUM_PPI = NUM_IRQ - NUM_SGI
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_PPI-1:0] line_i,
  input  logic [NUM_IRQ-1:0] edge_cfg_i,
  output logic [NUM_IRQ-1:0] lvl_o,
  output logic [NUM_IRQ-1:0] edge_set_o
);

  logic [NUM_PPI-1:0] lvl_q;

  assign lvl_o[NUM_SGI-1:0]      = '0;
  assign edge_set_o[NUM_SGI-1:0] = '0;

  for (genvar k = 0; k < NUM_PPI; k++) begin : g_line
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        lvl_q[k] <= 1'b0;
      end else if (line_i[k] != lvl_q[k]) begin
        lvl_q[k] <= line_i[k];
      end
    end

    assign lvl_o[NUM_SGI+k]      = lvl_q[k];
    assign edge_set_o[NUM_SGI+k] = edge_cfg_i[NUM_SGI+k] & line_i[k] & ~lvl_q[k];

    // R2: an edge set is always followed by a high stored level
    a_r2_edge_then_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_set_o[NUM_SGI+k] |=> lvl_o[NUM_SGI+k]);
  end

endmodule

// File: rtl/ppg_sgi_gate.sv
module ppg_sgi_gate
  import priv_pend_pkg::*;
#(
  parameter int NUM_SGI = 16,
  localparam int ID_W = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic [ID_W-1:0]      id_i,
  input  logic [1:0]           grp_req_i,
  input  logic                 ns_i,
  input  logic                 sec_off_i,
  input  logic [NUM_SGI-1:0]   grp_cfg_i,
  input  logic [NUM_SGI-1:0]   grp_mod_i,
  input  logic [2*NUM_SGI-1:0] ns_acc_i,
  output logic [NUM_SGI-1:0]   acc_o
);

  grp_e       cfg;
  grp_e       eff;
  logic [1:0] fld;
  logic       perm;

  always_comb begin
    cfg = cfg_grp(grp_cfg_i[id_i], grp_mod_i[id_i]);
    eff = grp_e'(grp_req_i);
    if (eff == GRP_1S && cfg == GRP_0) eff = GRP_0;
    fld  = ns_acc_i[{id_i, 1'b0} +: 2];
    perm = 1'b1;
    if (ns_i && !sec_off_i) perm = (fld >= ns_min_field(cfg));
    acc_o = '0;
    if (req_i && eff != GRP_BAD && eff == cfg && perm) acc_o[id_i] = 1'b1;
  end

  // R10: at most one ID accepted per request
  a_r10_one_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(acc_o));

  // R10: no request, no acceptance
  a_r10_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |-> acc_o == '0);

  // R7: invalid group encoding never accepted
  a_r7_bad_grp_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && grp_req_i == 2'd3) |-> acc_o == '0);

  // R8: zero field blocks non-secure request to group-0 or secure group-1 target
  a_r8_zero_field_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && ns_i && !sec_off_i && !grp_cfg_i[id_i]
     && ns_acc_i[{id_i, 1'b0} +: 2] == 2'd0) |-> acc_o == '0);

endmodule

// File: rtl/ppg_pend_latch.sv
module ppg_pend_latch #(
  parameter int NUM_IRQ = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_IRQ-1:0] set_edge_i,
  input  logic [NUM_IRQ-1:0] set_sgi_i,
  input  logic [NUM_IRQ-1:0] set_reg_i,
  input  logic [NUM_IRQ-1:0] clr_reg_i,
  input  logic [NUM_IRQ-1:0] lvl_i,
  input  logic [NUM_IRQ-1:0] edge_cfg_i,
  input  logic [NUM_IRQ-1:0] en_i,
  input  logic [NUM_IRQ-1:0] act_i,
  output logic [NUM_IRQ-1:0] pend_o,
  output logic [NUM_IRQ-1:0] deliv_o
);

  logic [NUM_IRQ-1:0] pend_q;
  logic [NUM_IRQ-1:0] set_all;
  logic [NUM_IRQ-1:0] clr_only;

  assign set_all  = set_edge_i | set_sgi_i | set_reg_i;
  assign clr_only = clr_reg_i & ~set_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= (pend_q & ~clr_reg_i) | set_all;
  end

  assign pend_o  = pend_q | (lvl_i & ~edge_cfg_i);
  assign deliv_o = pend_o & en_i & ~act_i;

  // R5/R12: every set source lands, regardless of a coincident clear
  a_r12_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_all != '0) |=> (pend_q & $past(set_all)) == $past(set_all));

  // R5: a clear without a set empties the latch bit
  a_r5_clear_takes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_only != '0) |=> (pend_q & $past(clr_only)) == '0);

  // R2: a bit with no set source cannot rise in the latch
  a_r2_no_spurious_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (pend_q & ~$past(pend_q) & ~$past(set_all)) == '0);

endmodule

// File: rtl/priv_pend_ctrl.sv
module priv_pend_ctrl #(
  parameter int NUM_IRQ = 32,
  parameter int NUM_SGI = 16,
  localparam int NUM_PPI = NUM_IRQ - NUM_SGI,
  localparam int ID_W    = $clog2(NUM_SGI)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PPI-1:0]   line_i,
  input  logic                 sgi_req_i,
  input  logic [ID_W-1:0]      sgi_id_i,
  input  logic [1:0]           sgi_grp_i,
  input  logic                 sgi_ns_i,
  input  logic                 sec_off_i,
  input  logic [NUM_IRQ-1:0]   grp_cfg_i,
  input  logic [NUM_IRQ-1:0]   grp_mod_i,
  input  logic [2*NUM_SGI-1:0] ns_acc_i,
  input  logic [NUM_IRQ-1:0]   edge_cfg_i,
  input  logic [NUM_IRQ-1:0]   en_i,
  input  logic [NUM_IRQ-1:0]   act_i,
  input  logic [NUM_IRQ-1:0]   set_pend_i,
  input  logic [NUM_IRQ-1:0]   clr_pend_i,
  output logic [NUM_IRQ-1:0]   pend_o,
  output logic [NUM_IRQ-1:0]   deliv_o
);

  logic [NUM_IRQ-1:0] lvl;
  logic [NUM_IRQ-1:0] edge_set;
  logic [NUM_SGI-1:0] sgi_acc;
  logic [NUM_IRQ-1:0] sgi_set;

  ppg_line_sampler #(.NUM_IRQ(NUM_IRQ), .NUM_SGI(NUM_SGI)) u_lines (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .line_i     (line_i),
    .edge_cfg_i (edge_cfg_i),
    .lvl_o      (lvl),
    .edge_set_o (edge_set)
  );

  ppg_sgi_gate #(.NUM_SGI(NUM_SGI)) u_gate (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (sgi_req_i),
    .id_i      (sgi_id_i),
    .grp_req_i (sgi_grp_i),
    .ns_i      (sgi_ns_i),
    .sec_off_i (sec_off_i),
    .grp_cfg_i (grp_cfg_i[NUM_SGI-1:0]),
    .grp_mod_i (grp_mod_i[NUM_SGI-1:0]),
    .ns_acc_i  (ns_acc_i),
    .acc_o     (sgi_acc)
  );

  assign sgi_set = {{NUM_PPI{1'b0}}, sgi_acc};

  ppg_pend_latch #(.NUM_IRQ(NUM_IRQ)) u_pend (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_edge_i (edge_set),
    .set_sgi_i  (sgi_set),
    .set_reg_i  (set_pend_i),
    .clr_reg_i  (clr_pend_i),
    .lvl_i      (lvl),
    .edge_cfg_i (edge_cfg_i),
    .en_i       (en_i),
    .act_i      (act_i),
    .pend_o     (pend_o),
    .deliv_o    (deliv_o)
  );

  // R11: a delivered ID is never active and always enabled
  a_r11_deliv_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((deliv_o & act_i) == '0) && ((deliv_o & ~en_i) == '0));

endmodule

// File: tb/tb_priv_pend_ctrl.sv
module tb_priv_pend_ctrl;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] line_i = '0;
  logic        sgi_req_i = 1'b0;
  logic [3:0]  sgi_id_i = '0;
  logic [1:0]  sgi_grp_i = '0;
  logic        sgi_ns_i = 1'b0;
  logic        sec_off_i = 1'b0;
  logic [31:0] grp_cfg_i = '0, grp_mod_i = '0, ns_acc_i = '0, edge_cfg_i = '0;
  logic [31:0] en_i = '0, act_i = '0, set_pend_i = '0, clr_pend_i = '0;
  logic [31:0] pend_o, deliv_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  priv_pend_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .line_i(line_i),
    .sgi_req_i(sgi_req_i), .sgi_id_i(sgi_id_i), .sgi_grp_i(sgi_grp_i),
    .sgi_ns_i(sgi_ns_i), .sec_off_i(sec_off_i),
    .grp_cfg_i(grp_cfg_i), .grp_mod_i(grp_mod_i), .ns_acc_i(ns_acc_i),
    .edge_cfg_i(edge_cfg_i), .en_i(en_i), .act_i(act_i),
    .set_pend_i(set_pend_i), .clr_pend_i(clr_pend_i),
    .pend_o(pend_o), .deliv_o(deliv_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  // {sec_off, ns, req_grp[1:0], id[3:0], grp_bit, mod_bit, field[1:0], accept}
  localparam int NV = 14;
  localparam logic [12:0] VEC [NV] = '{
    {1'b0, 1'b0, 2'd0, 4'd3,  1'b0, 1'b0, 2'd0, 1'b1},
    {1'b0, 1'b0, 2'd1, 4'd5,  1'b0, 1'b0, 2'd0, 1'b1},
    {1'b0, 1'b0, 2'd0, 4'd6,  1'b0, 1'b1, 2'd3, 1'b0},
    {1'b0, 1'b0, 2'd2, 4'd7,  1'b0, 1'b0, 2'd3, 1'b0},
    {1'b0, 1'b0, 2'd3, 4'd8,  1'b1, 1'b1, 2'd3, 1'b0},
    {1'b0, 1'b1, 2'd0, 4'd9,  1'b0, 1'b0, 2'd0, 1'b0},
    {1'b0, 1'b1, 2'd0, 4'd10, 1'b0, 1'b0, 2'd1, 1'b1},
    {1'b0, 1'b1, 2'd1, 4'd11, 1'b0, 1'b1, 2'd1, 1'b0},
    {1'b0, 1'b1, 2'd1, 4'd12, 1'b0, 1'b1, 2'd2, 1'b1},
    {1'b0, 1'b1, 2'd1, 4'd13, 1'b0, 1'b0, 2'd1, 1'b1},
    {1'b0, 1'b1, 2'd2, 4'd14, 1'b1, 1'b0, 2'd0, 1'b1},
    {1'b1, 1'b1, 2'd0, 4'd1,  1'b0, 1'b0, 2'd0, 1'b1},
    {1'b1, 1'b1, 2'd1, 4'd2,  1'b0, 1'b1, 2'd0, 1'b1},
    {1'b0, 1'b1, 2'd0, 4'd15, 1'b0, 1'b0, 2'd3, 1'b1}
  };

  initial begin
    #800000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: reset holds everything clear even with set pulses
    set_pend_i = '1;
    en_i = '1;
    tick(); tick();
    chk("R1 pend in reset", pend_o, '0);
    chk("R1 deliv in reset", deliv_o, '0);
    set_pend_i = '0;
    en_i = '0;
    tick();
    rst_ni = 1'b1;
    tick();
    chk("R1 pend after reset", pend_o, '0);

    // software request vectors: R6..R10
    for (int i = 0; i < NV; i++) begin
      logic [12:0] v;
      logic [3:0]  id;
      logic [31:0] exp;
      string       tag;
      v  = VEC[i];
      id = v[8:5];
      clr_pend_i = '1;
      tick();
      clr_pend_i = '0;
      sec_off_i  = v[12];
      sgi_ns_i   = v[11];
      sgi_grp_i  = v[10:9];
      sgi_id_i   = id;
      grp_cfg_i  = v[4] ? (32'd1 << id) : ~(32'd1 << id);
      grp_mod_i  = v[3] ? (32'd1 << id) : ~(32'd1 << id);
      ns_acc_i   = (~(32'd3 << (2 * id))) | ({30'd0, v[2:1]} << (2 * id));
      sgi_req_i  = 1'b1;
      tick();
      sgi_req_i = 1'b0;
      exp = v[0] ? (32'd1 << id) : 32'd0;
      if (v[12])                             tag = "R9 sec off";
      else if (v[11])                        tag = "R8 ns field";
      else if (v[10:9] == 2'd1 && !v[4] && !v[3]) tag = "R6 coercion";
      else if (v[0])                         tag = "R10 accept";
      else                                   tag = "R7 group mismatch";
      chk(tag, pend_o, exp);
    end
    sec_off_i = 1'b0;
    clr_pend_i = '1;
    tick();
    clr_pend_i = '0;
    tick();
    chk("R10 cleared before line tests", pend_o, '0);

    // R2: edge line ID 20 (line bit 4)
    edge_cfg_i = 32'd1 << 20;
    line_i[4] = 1'b1;
    tick();
    chk("R2 rise latches", pend_o, 32'd1 << 20);
    line_i[4] = 1'b0;
    tick();
    chk("R2 latch holds after fall", pend_o, 32'd1 << 20);
    clr_pend_i = 32'd1 << 20;
    tick();
    clr_pend_i = '0;
    chk("R5 clear pulse", pend_o, '0);
    line_i[4] = 1'b1;
    clr_pend_i = 32'd1 << 20;
    tick();
    clr_pend_i = '0;
    chk("R12 edge beats clear", pend_o, 32'd1 << 20);
    clr_pend_i = 32'd1 << 20;
    tick();
    clr_pend_i = '0;
    chk("R2 cleared while held high", pend_o, '0);
    tick();
    chk("R2 no reset from steady high", pend_o, '0);

    // R3/R4: level line ID 25 (line bit 9), line 4 still high
    line_i[9] = 1'b1;
    tick();
    chk("R3 level rise", pend_o, 32'd1 << 25);
    line_i[9] = 1'b0;
    tick();
    chk("R3 level fall", pend_o, '0);
    line_i[9] = 1'b1;
    set_pend_i = 32'd1 << 25;
    tick();
    set_pend_i = '0;
    line_i[9] = 1'b0;
    tick();
    chk("R4 latch keeps level ID", pend_o, 32'd1 << 25);
    line_i[9] = 1'b1;
    clr_pend_i = 32'd1 << 25;
    tick();
    clr_pend_i = '0;
    chk("R4 level survives clear", pend_o, 32'd1 << 25);
    line_i[9] = 1'b0;
    tick();
    chk("R4 level gone", pend_o, '0);

    // R5: set and clear collide
    set_pend_i = 32'd1 << 7;
    clr_pend_i = 32'd1 << 7;
    tick();
    set_pend_i = '0;
    clr_pend_i = '0;
    chk("R5 set beats clear", pend_o, 32'd1 << 7);
    clr_pend_i = 32'd1 << 7;
    tick();
    clr_pend_i = '0;
    chk("R5 clear alone", pend_o, '0);

    // R12: accepted request beats clear
    sgi_id_i = 4'd4; sgi_grp_i = 2'd0; sgi_ns_i = 1'b0;
    grp_cfg_i = '0; grp_mod_i = '0;
    sgi_req_i = 1'b1;
    clr_pend_i = 32'd1 << 4;
    tick();
    sgi_req_i = 1'b0;
    clr_pend_i = '0;
    chk("R12 request beats clear", pend_o, 32'd1 << 4);
    clr_pend_i = '1;
    tick();
    clr_pend_i = '0;

    // R11: deliverable gating
    set_pend_i = 32'h0000_00F0;
    en_i  = 32'h0000_0030;
    act_i = 32'h0000_0020;
    tick();
    set_pend_i = '0;
    chk("R11 pend", pend_o, 32'h0000_00F0);
    chk("R11 deliv", deliv_o, 32'h0000_0010);
    act_i = '0;
    tick();
    chk("R11 deliv after active drops", deliv_o, 32'h0000_0030);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule